// File: doc/BRIEF.md
# SPI Potentiometer Command Decoder

This block is the serial front end of a dual digital potentiometer. It acts as an SPI slave. The SCK, chip-select, data-in and hold pins are oversampled in the system clock domain. Each frame is checked against a fixed device-type nibble and a two-bit pin-strap address. The block then decodes an instruction byte that packs an opcode, a data-register pointer and a pot pointer. It sends command strobes to a separate register store. That store holds the wiper registers and the non-volatile data registers, and it answers with a read value and a write-in-progress flag.

Frames are two or three bytes long, depending on the opcode. The increment/decrement mode is the exception: once its instruction byte is in, every further SCK pulse moves the selected wiper by one step. Writes and transfers are committed only when chip select returns high on a byte boundary. Read data and status go out on a serial output that is modelled as a data bit plus an output enable. A hold input pauses the transfer in mid-frame.

Top module: `spi_pot_decoder`

## Requirements
- R1: SI is sampled on SCK rising edges, most significant bit first. Read data leaves on so_data, MSB first, and each bit changes after an SCK falling edge. The first bit appears on the falling edge that follows the last instruction bit.
- R2: The first byte must be 0101 in bits 7:4 and 00 in bits 3:2, and bits 1:0 must equal addr_pins. On any mismatch the rest of the frame gives no command and no output until chip select rises.
- R3: In the instruction byte, bits 7:4 are the opcode, bits 3:2 are the register pointer and bits 1:0 are the pot pointer. The two pointers are presented on cmd_reg and cmd_pot.
- R4: Opcode 1001 (read wiper) sets rd_src=0 and opcode 1011 (read data register) sets rd_src=1. In both cases the third byte shifts out the rd_data value captured at its first falling edge.
- R5: Opcode 0101 (read status) sets rd_src=2. It shifts out a byte whose bit 0 is wip and whose other bits are 0.
- R6: Opcode 1010 (write wiper) and opcode 1100 (write data register) capture the third byte into cmd_wdata. At chip-select rise they issue one cmd_valid pulse with cmd_kind 0 or 1 respectively.
- R7: The two-byte transfer opcodes are 1101 (data to wiper), 1110 (wiper to data), 0001 (global data to wiper) and 1000 (global wiper to data). At chip-select rise they issue cmd_kind 2, 3, 4 and 5 respectively.
- R8: After opcode 0010, each accepted SCK rising edge at once issues a cmd_valid pulse. cmd_kind is 6 (step up) when SI is 1 and 7 (step down) when SI is 0.
- R9: A pending write or transfer is dropped if chip select rises with a partial byte clocked. It is also dropped if chip select rises in the same sampled cycle as an SCK rise that would have completed a byte. An opcode outside the table gives no command.
- R10: Only a chip-select falling edge starts a frame, so full bytes that follow a finished command in the same frame are ignored. so_oe is 0 while chip select is high.
- R11: While hold_n is low, SCK edges and SI are ignored and so_oe is 0. The frame continues where it stopped once hold_n returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer pause |
| addr_pins | input | 2 | Pin-strap address compared with the first byte |
| rd_data | input | 8 | Wiper or data register value from the store, selected by rd_src and the pointers |
| wip | input | 1 | Write-in-progress flag from the store |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 3 | Command code: 0 wr wiper, 1 wr data, 2 d->w, 3 w->d, 4 global d->w, 5 global w->d, 6 step up, 7 step down |
| cmd_reg | output | 2 | Data register pointer |
| cmd_pot | output | 2 | Pot pointer |
| cmd_wdata | output | 8 | Write data for kinds 0 and 1 |
| rd_src | output | 2 | Read source: 0 wiper, 1 data register, 2 status |
| so_data | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so_data |

## Verification
Chip-select rise and an SCK rise can land in the same sampled cycle. The edge that wins decides whether a pending command commits. The bench provokes this by sending a transfer, then seven more bits, and then raising SCK and chip select in the same timestep. The expected result is that no strobe appears, because the eighth bit never counts and the partial byte discards the command. A second overlap is hold against a frame that is still running: SCK is toggled while paused. The check is that the command or the read bits that follow are unchanged and that so_oe stays low during the pause.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 2;
    localparam int OP_W   = 4;
    localparam int KIND_W = 3;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [OP_W-1:0] DEV_TYPE    = 4'b0101;
    localparam logic [OP_W-1:0] OP_RD_WIPER = 4'b1001;
    localparam logic [OP_W-1:0] OP_WR_WIPER = 4'b1010;
    localparam logic [OP_W-1:0] OP_RD_DATA  = 4'b1011;
    localparam logic [OP_W-1:0] OP_WR_DATA  = 4'b1100;
    localparam logic [OP_W-1:0] OP_D2W      = 4'b1101;
    localparam logic [OP_W-1:0] OP_W2D      = 4'b1110;
    localparam logic [OP_W-1:0] OP_GLB_D2W  = 4'b0001;
    localparam logic [OP_W-1:0] OP_GLB_W2D  = 4'b1000;
    localparam logic [OP_W-1:0] OP_STEP     = 4'b0010;
    localparam logic [OP_W-1:0] OP_STATUS   = 4'b0101;

    typedef enum logic [KIND_W-1:0] {
        K_WR_WIPER = 3'd0,
        K_WR_DATA  = 3'd1,
        K_D2W      = 3'd2,
        K_W2D      = 3'd3,
        K_GLB_D2W  = 3'd4,
        K_GLB_W2D  = 3'd5,
        K_INC      = 3'd6,
        K_DEC      = 3'd7
    } cmd_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_INSTR,
        PH_RDATA,
        PH_WDATA,
        PH_STEP,
        PH_DONE,
        PH_REJECT
    } phase_e;

    typedef enum logic [1:0] {
        SRC_WIPER  = 2'd0,
        SRC_DATA   = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;
endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
    parameter int          N       = 4,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level
);
    logic [N-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign level = stage_q[STAGES-1];
endmodule

// File: rtl/spi_pot_ctrl.sv
module spi_pot_ctrl
    import spi_pot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              si_s,
    input  logic              cs_low,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              hold_ok,
    input  logic [PTR_W-1:0]  addr_pins,
    output logic              cmd_valid,
    output logic [KIND_W-1:0] cmd_kind,
    output logic [PTR_W-1:0]  cmd_reg,
    output logic [PTR_W-1:0]  cmd_pot,
    output logic [BYTE_W-1:0] cmd_wdata,
    output rd_src_e           rd_src,
    output logic              reading
);
    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    bitcnt;
        logic [BYTE_W-1:0]   shreg;
        logic [PTR_W-1:0]    reg_ptr;
        logic [PTR_W-1:0]    pot_ptr;
        logic [BYTE_W-1:0]   wdata;
        logic                pending;
        cmd_kind_e           pend_kind;
        rd_src_e             src;
        logic                strobe;
        cmd_kind_e           strobe_kind;
    } ctrl_t;

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    ctrl_t st_d, st_q;
    logic [BYTE_W-1:0] byte_now;
    logic              take_bit;

    assign byte_now = {st_q.shreg[BYTE_W-2:0], si_s};
    assign take_bit = sck_rise && hold_ok && cs_low;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (cs_fall) begin
            st_d.phase   = PH_ADDR;
            st_d.bitcnt  = '0;
            st_d.pending = 1'b0;
        end else if (cs_rise) begin
            if (st_q.pending && st_q.bitcnt == '0) begin
                st_d.strobe      = 1'b1;
                st_d.strobe_kind = st_q.pend_kind;
            end
            st_d.pending = 1'b0;
            st_d.phase   = PH_IDLE;
            st_d.bitcnt  = '0;
        end else if (take_bit) begin
            case (st_q.phase)
                PH_IDLE, PH_REJECT: begin
                end
                PH_STEP: begin
                    st_d.strobe      = 1'b1;
                    st_d.strobe_kind = si_s ? K_INC : K_DEC;
                end
                default: begin
                    st_d.shreg  = byte_now;
                    st_d.bitcnt = st_q.bitcnt + 1'b1;
                    if (st_q.bitcnt == LAST_BIT) begin
                        case (st_q.phase)
                            PH_ADDR: begin
                                if (byte_now[7:4] == DEV_TYPE &&
                                    byte_now[3:2] == 2'b00 &&
                                    byte_now[1:0] == addr_pins)
                                    st_d.phase = PH_INSTR;
                                else
                                    st_d.phase = PH_REJECT;
                            end
                            PH_INSTR: begin
                                st_d.reg_ptr = byte_now[3:2];
                                st_d.pot_ptr = byte_now[1:0];
                                st_d.phase   = PH_DONE;
                                case (byte_now[7:4])
                                    OP_RD_WIPER: begin
                                        st_d.src   = SRC_WIPER;
                                        st_d.phase = PH_RDATA;
                                    end
                                    OP_RD_DATA: begin
                                        st_d.src   = SRC_DATA;
                                        st_d.phase = PH_RDATA;
                                    end
                                    OP_STATUS: begin
                                        st_d.src   = SRC_STATUS;
                                        st_d.phase = PH_RDATA;
                                    end
                                    OP_WR_WIPER: begin
                                        st_d.pend_kind = K_WR_WIPER;
                                        st_d.phase     = PH_WDATA;
                                    end
                                    OP_WR_DATA: begin
                                        st_d.pend_kind = K_WR_DATA;
                                        st_d.phase     = PH_WDATA;
                                    end
                                    OP_D2W: begin
                                        st_d.pend_kind = K_D2W;
                                        st_d.pending   = 1'b1;
                                    end
                                    OP_W2D: begin
                                        st_d.pend_kind = K_W2D;
                                        st_d.pending   = 1'b1;
                                    end
                                    OP_GLB_D2W: begin
                                        st_d.pend_kind = K_GLB_D2W;
                                        st_d.pending   = 1'b1;
                                    end
                                    OP_GLB_W2D: begin
                                        st_d.pend_kind = K_GLB_W2D;
                                        st_d.pending   = 1'b1;
                                    end
                                    OP_STEP: st_d.phase = PH_STEP;
                                    default: st_d.phase = PH_REJECT;
                                endcase
                            end
                            PH_WDATA: begin
                                st_d.wdata   = byte_now;
                                st_d.pending = 1'b1;
                                st_d.phase   = PH_DONE;
                            end
                            PH_RDATA: st_d.phase = PH_DONE;
                            default: begin
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, bitcnt: '0, shreg: '0, reg_ptr: '0,
                      pot_ptr: '0, wdata: '0, pending: 1'b0,
                      pend_kind: K_WR_WIPER, src: SRC_WIPER, strobe: 1'b0,
                      strobe_kind: K_WR_WIPER};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_valid = st_q.strobe;
    assign cmd_kind  = st_q.strobe_kind;
    assign cmd_reg   = st_q.reg_ptr;
    assign cmd_pot   = st_q.pot_ptr;
    assign cmd_wdata = st_q.wdata;
    assign rd_src    = st_q.src;
    assign reading   = (st_q.phase == PH_RDATA);

    // R11: a paused bus does not advance the frame
    p_hold_freezes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_ok && !cs_fall && !cs_rise) |=>
            ($stable(st_q.bitcnt) && $stable(st_q.phase)));

    // R2: a rejected frame never strobes
    p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_REJECT && !cs_fall) |=> !st_q.strobe);

    // R9: strobes only follow a chip-select rise or an SCK rise
    p_strobe_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |-> $past(cs_rise || sck_rise));
endmodule

// File: rtl/spi_pot_out.sv
module spi_pot_out
    import spi_pot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_fall,
    input  logic              cs_low,
    input  logic              hold_ok,
    input  logic              reading,
    input  rd_src_e           rd_src,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              wip,
    output logic              so_data,
    output logic              so_oe
);
    typedef struct packed {
        logic [BYTE_W-1:0] shreg;
        logic              loaded;
        logic              bit_out;
        logic              oe;
    } out_t;

    out_t ob_d, ob_q;
    logic [BYTE_W-1:0] load_val;
    logic              do_load;

    assign load_val = (rd_src == SRC_STATUS) ? {{(BYTE_W-1){1'b0}}, wip} : rd_data;
    assign do_load  = reading && sck_fall && cs_low && hold_ok && !ob_q.loaded;

    always_comb begin
        ob_d    = ob_q;
        ob_d.oe = cs_low && hold_ok && reading;
        if (!reading) begin
            ob_d.loaded = 1'b0;
        end else if (sck_fall && cs_low && hold_ok) begin
            if (!ob_q.loaded) begin
                ob_d.bit_out = load_val[BYTE_W-1];
                ob_d.shreg   = load_val << 1;
                ob_d.loaded  = 1'b1;
            end else begin
                ob_d.bit_out = ob_q.shreg[BYTE_W-1];
                ob_d.shreg   = ob_q.shreg << 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ob_q <= '0;
        else        ob_q <= ob_d;
    end

    assign so_data = ob_q.bit_out;
    assign so_oe   = ob_q.oe;

    // R10: chip select high turns the output off
    p_oe_off_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |=> !so_oe);

    // R11: hold turns the output off
    p_oe_off_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ok |=> !so_oe);

    // R5: status MSB is zero
    p_status_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_load && rd_src == SRC_STATUS) |=> !so_data);
endmodule

// File: rtl/spi_pot_decoder.sv
module spi_pot_decoder
    import spi_pot_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_n,
    input  logic [PTR_W-1:0]  addr_pins,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              wip,
    output logic              cmd_valid,
    output logic [KIND_W-1:0] cmd_kind,
    output logic [PTR_W-1:0]  cmd_reg,
    output logic [PTR_W-1:0]  cmd_pot,
    output logic [BYTE_W-1:0] cmd_wdata,
    output logic [1:0]        rd_src,
    output logic              so_data,
    output logic              so_oe
);
    localparam int PIN_N = 4;
    localparam logic [PIN_N-1:0] PIN_RST = 4'b1100;

    logic [PIN_N-1:0] pins_s;
    logic sck_s, si_s, cs_n_s, hold_n_s;
    logic sck_prev_q, cs_prev_q;
    logic sck_rise, sck_fall, cs_fall, cs_rise, cs_low;
    logic reading;
    rd_src_e src;

    spi_pot_sync #(.N(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({hold_n, cs_n, si, sck}),
        .level    (pins_s)
    );

    assign sck_s    = pins_s[0];
    assign si_s     = pins_s[1];
    assign cs_n_s   = pins_s[2];
    assign hold_n_s = pins_s[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            cs_prev_q  <= 1'b1;
        end else begin
            sck_prev_q <= sck_s;
            cs_prev_q  <= cs_n_s;
        end
    end

    assign sck_rise = sck_s & ~sck_prev_q;
    assign sck_fall = ~sck_s & sck_prev_q;
    assign cs_fall  = ~cs_n_s & cs_prev_q;
    assign cs_rise  = cs_n_s & ~cs_prev_q;
    assign cs_low   = ~cs_n_s;

    spi_pot_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .si_s      (si_s),
        .cs_low    (cs_low),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .hold_ok   (hold_n_s),
        .addr_pins (addr_pins),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_reg   (cmd_reg),
        .cmd_pot   (cmd_pot),
        .cmd_wdata (cmd_wdata),
        .rd_src    (src),
        .reading   (reading)
    );

    spi_pot_out out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_fall (sck_fall),
        .cs_low   (cs_low),
        .hold_ok  (hold_n_s),
        .reading  (reading),
        .rd_src   (src),
        .rd_data  (rd_data),
        .wip      (wip),
        .so_data  (so_data),
        .so_oe    (so_oe)
    );

    assign rd_src = src;
endmodule

// File: tb/spi_pot_decoder_tb.sv
module spi_pot_decoder_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wip = 1'b0;
    logic [1:0] addr_pins = 2'b10;
    logic [7:0] rd_data;
    logic       cmd_valid, so_data, so_oe;
    logic [2:0] cmd_kind;
    logic [1:0] cmd_reg, cmd_pot, rd_src;
    logic [7:0] cmd_wdata;

    int compared = 0;
    int mismatched = 0;
    int cs_hi_cnt = 0;
    logic [14:0] exp_q [$];

    always #2.5 clk = ~clk;

    spi_pot_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .hold_n(hold_n), .addr_pins(addr_pins), .rd_data(rd_data), .wip(wip),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_reg(cmd_reg),
        .cmd_pot(cmd_pot), .cmd_wdata(cmd_wdata), .rd_src(rd_src),
        .so_data(so_data), .so_oe(so_oe)
    );

    // register store model: wiper p = 0x30+p, data (p,r) = 0xA0+{p,r}
    always_comb begin
        if (rd_src == 2'd1) rd_data = 8'hA0 + {4'h0, cmd_pot, cmd_reg};
        else                rd_data = 8'h30 + {6'h0, cmd_pot};
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (cs_n) cs_hi_cnt <= cs_hi_cnt + 1;
        else      cs_hi_cnt <= 0;
    end

    // per-clock comparison against the reference expectations
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_hi_cnt > 4) check("R10 so_oe with cs high", {31'd0, so_oe}, 0);
            if (cmd_valid) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected command", {29'd0, cmd_kind}, 32'hFFFF);
                end else begin
                    logic [14:0] e;
                    e = exp_q.pop_front();
                    check("R6/R7/R8 command", {17'd0, cmd_kind, cmd_reg, cmd_pot,
                          (cmd_kind <= 3'd1) ? cmd_wdata : 8'h00}, {17'd0, e});
                end
            end
        end
    end

    function automatic logic [14:0] cmd(input int kind, input int rg, input int pt, input int wd);
        return {kind[2:0], rg[1:0], pt[1:0], (kind <= 1) ? wd[7:0] : 8'h00};
    endfunction

    // mode: 0 no check, 1 expect data bit, 2 expect output off
    task automatic send_bit(input logic b, input int mode, input logic eb, input string req);
        si = b;
        repeat (4) @(negedge clk);
        if (mode == 1) begin
            check({req, " so_oe"}, {31'd0, so_oe}, 1);
            check({req, " so_data"}, {31'd0, so_data}, {31'd0, eb});
        end else if (mode == 2) begin
            check({req, " so_oe off"}, {31'd0, so_oe}, 0);
        end
        sck = 1'b1;
        repeat (8) @(negedge clk);
        sck = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] tx, input int mode, input logic [7:0] ex, input string req);
        for (int i = 7; i >= 0; i--) send_bit(tx[i], mode, ex[i], req);
    endtask

    task automatic cs_start();
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic frame2(input logic [7:0] b0, input logic [7:0] b1);
        cs_start(); send_byte(b0, 0, 0, ""); send_byte(b1, 0, 0, ""); cs_end();
    endtask

    task automatic frame3(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                          input int mode, input logic [7:0] ex, input string req);
        cs_start(); send_byte(b0, 0, 0, ""); send_byte(b1, 0, 0, "");
        send_byte(b2, mode, ex, req); cs_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        check("R10 reset so_oe", {31'd0, so_oe}, 0);
        check("R6 reset cmd_valid", {31'd0, cmd_valid}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1 R4: read wiper pot1 -> 0x31, MSB first
        frame3(8'h52, 8'h91, 8'h00, 1, 8'h31, "R1 R4 read wiper");
        check("R4 rd_src wiper", {30'd0, rd_src}, 0);
        check("R3 pot pointer", {30'd0, cmd_pot}, 1);
        // R4: read data reg2 pot0 -> 0xA2
        frame3(8'h52, 8'hB8, 8'h00, 1, 8'hA2, "R4 read data");
        check("R4 rd_src data", {30'd0, rd_src}, 1);
        check("R3 reg pointer", {30'd0, cmd_reg}, 2);
        // R5: status
        wip = 1'b1;
        frame3(8'h52, 8'h51, 8'h00, 1, 8'h01, "R5 status wip=1");
        wip = 1'b0;
        frame3(8'h52, 8'h51, 8'hFF, 1, 8'h00, "R5 status wip=0");

        // R6: writes commit at cs rise
        exp_q.push_back(cmd(0, 0, 1, 8'h5C));
        frame3(8'h52, 8'hA1, 8'h5C, 0, 0, "R6");
        exp_q.push_back(cmd(1, 3, 0, 8'h81));
        frame3(8'h52, 8'hCC, 8'h81, 0, 0, "R6");

        // R7: transfers
        exp_q.push_back(cmd(2, 2, 1, 0)); frame2(8'h52, 8'hD9);
        exp_q.push_back(cmd(3, 1, 0, 0)); frame2(8'h52, 8'hE4);
        exp_q.push_back(cmd(4, 3, 0, 0)); frame2(8'h52, 8'h1C);
        exp_q.push_back(cmd(5, 2, 0, 0)); frame2(8'h52, 8'h88);

        // R8: step mode, pot1: up, up, down
        cs_start();
        send_byte(8'h52, 0, 0, ""); send_byte(8'h21, 0, 0, "");
        exp_q.push_back(cmd(6, 0, 1, 0)); send_bit(1'b1, 0, 0, "R8");
        exp_q.push_back(cmd(6, 0, 1, 0)); send_bit(1'b1, 0, 0, "R8");
        exp_q.push_back(cmd(7, 0, 1, 0)); send_bit(1'b0, 0, 0, "R8");
        cs_end();

        // R2: bad pin address, bad type, A3 set -> nothing, output stays off
        frame3(8'h53, 8'h91, 8'h00, 2, 0, "R2 pin mismatch");
        frame2(8'h72, 8'hD5);
        frame2(8'h5A, 8'hE4);
        // R9: opcodes outside the table
        frame2(8'h52, 8'h71);
        frame3(8'h52, 8'h35, 8'h44, 2, 0, "R9 unknown opcode");
        // R9: trailing partial byte drops write
        cs_start();
        send_byte(8'h52, 0, 0, ""); send_byte(8'hA1, 0, 0, ""); send_byte(8'h11, 0, 0, "");
        send_bit(1'b1, 0, 0, ""); send_bit(1'b0, 0, 0, ""); send_bit(1'b1, 0, 0, "");
        cs_end();
        // R9: eighth bit coincides with cs rise -> bit not counted, transfer dropped
        cs_start();
        send_byte(8'h52, 0, 0, ""); send_byte(8'hD9, 0, 0, "");
        for (int i = 0; i < 7; i++) send_bit(1'b0, 0, 0, "");
        si = 1'b0;
        repeat (4) @(negedge clk);
        sck = 1'b1; cs_n = 1'b1;
        repeat (8) @(negedge clk);
        sck = 1'b0;
        repeat (12) @(negedge clk);

        // R10: a second command in the same frame is ignored
        exp_q.push_back(cmd(3, 2, 1, 0));
        cs_start();
        send_byte(8'h52, 0, 0, ""); send_byte(8'hE9, 0, 0, "");
        send_byte(8'h52, 0, 0, ""); send_byte(8'hD4, 0, 0, "");
        cs_end();

        // R11: hold in write data, SCK toggled while paused
        exp_q.push_back(cmd(1, 1, 1, 8'h3C));
        cs_start();
        send_byte(8'h52, 0, 0, ""); send_byte(8'hC5, 0, 0, "");
        send_bit(0, 0, 0, ""); send_bit(0, 0, 0, ""); send_bit(1, 0, 0, ""); send_bit(1, 0, 0, "");
        hold_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            si = i[0]; sck = 1'b1; repeat (8) @(negedge clk);
            sck = 1'b0; repeat (8) @(negedge clk);
        end
        hold_n = 1'b1;
        repeat (6) @(negedge clk);
        send_bit(1, 0, 0, ""); send_bit(1, 0, 0, ""); send_bit(0, 0, 0, ""); send_bit(0, 0, 0, "");
        cs_end();

        // R11: hold during read, output off, then bits resume
        cs_start();
        send_byte(8'h52, 0, 0, ""); send_byte(8'h90, 0, 0, "");
        for (int i = 7; i >= 5; i--) send_bit(1'b0, 1, 1'(8'h30 >> i), "R11 read before hold");
        hold_n = 1'b0;
        repeat (8) @(negedge clk);
        check("R11 so_oe during hold", {31'd0, so_oe}, 0);
        sck = 1'b1; repeat (8) @(negedge clk); sck = 1'b0; repeat (8) @(negedge clk);
        hold_n = 1'b1;
        repeat (8) @(negedge clk);
        for (int i = 4; i >= 0; i--) send_bit(1'b0, 1, 1'(8'h30 >> i), "R11 read after hold");
        cs_end();

        repeat (20) @(negedge clk);
        check("R9 leftover expected commands", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule